// File: doc/BRIEF.md
# Host Port Status and Control Register

This block is the single status/control register that a USB-style host controller exposes for its root port. Software writes it through a plain write strobe with a data word, and the current register value is always presented on a read bus. Port-side logic feeds it the connect level, the overcurrent level, the line state, the detected speed, and a one-cycle grant pulse. The port logic raises that pulse when a bus reset has finished on a connected device.

The register holds the software-owned controls: power, bus reset, suspend, resume and a test-mode code. It also holds three sticky change flags, each cleared by writing 1 to it, and the port-enable bit. Software can only clear the port-enable bit, and it does so by writing 1. Because the enable bit sits among the clear-on-one flags, read-modify-write code has to mask bits 1, 2, 3 and 5 (mask 0x2E) before writing back. A registered port interrupt is the OR of the pending change flags.

Top module: `hport_port_reg`

## Requirements
- R1: After reset the read value is 0, the port interrupt is low, and the enable, power, bus-reset, suspend, resume and test outputs are all 0. This holds while the sideband inputs are 0.
- R2: Bit 0 reads the connect level one clock after the input changes. Bit 1, the connect-change flag, sets in that same clock on either a rising or a falling connect edge.
- R3: Bit 4 reads the overcurrent level one clock after the input changes. Bit 5, the overcurrent-change flag, sets in that same clock on either edge of the overcurrent input.
- R4: Writing 1 to bit 1, 3 or 5 clears only that flag. Writing 0 to a flag leaves it unchanged.
- R5: When a flag's hardware set and a software clear of that flag fall in the same clock, the flag ends set.
- R6: The enable bit (bit 2) sets in the clock after a grant pulse that arrives while the port reads connected and no overcurrent is present. Writing 1 to bit 2 clears it. No write can set it, and writing 0 to it leaves it unchanged.
- R7: The enable bit clears by itself on disconnect or on overcurrent, and that clearing also sets bit 3, the enable-change flag. A software clear of the enable bit does not set bit 3.
- R8: The control fields can be written and read back, and each one drives its output: resume at bit 6, suspend at bit 7, bus reset at bit 8, power at bit 12, and the test code at bits 16:13.
- R9: The line state reads at bits 11:10 and the port speed at bits 18:17, each one clock after its input changes. Writes to those bits, and writes to bits 0 and 4, have no effect.
- R10: The port interrupt rises one clock after any change flag becomes set. It falls one clock after the last pending flag is cleared.
- R11: Writing back a read value with mask 0x2E cleared changes only the control fields and keeps the enable bit and the pending flags. Writing back the raw read value clears both the pending flags and the enable bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | DATA_W | Register write data |
| rd_data_o | output | DATA_W | Current register value |
| conn_i | input | 1 | Device connected level from the port |
| ovc_i | input | 1 | Overcurrent level from the port |
| en_grant_i | input | 1 | Pulse: bus reset finished on a connected device |
| line_i | input | LINE_W | Data line state |
| speed_i | input | SPD_W | Detected device speed |
| port_pwr_o | output | 1 | Port power control |
| port_rst_o | output | 1 | Bus reset control |
| port_susp_o | output | 1 | Suspend control |
| port_res_o | output | 1 | Resume control |
| port_test_o | output | TEST_W | Test-mode code |
| port_en_o | output | 1 | Port enabled |
| port_irq_o | output | 1 | Registered port interrupt |

## Verification
The bench builds the register with a 32-bit data word, a 2-bit line state, a 4-bit test code and a 2-bit speed, with the test field present. These values give the field positions stated in the requirements and bring a non-trivial test code and both speed bits within reach. They also place the masked write-back of R11 on real neighbouring fields. The variant without the test field is not exercised.

// File: rtl/hport_pkg.sv
package hport_pkg;

   // Bit positions that software masks depend on
   localparam int CONN_STS_B = 0;
   localparam int EN_B       = 2;
   localparam int OVC_STS_B  = 4;
   localparam int RESUME_B   = 6;
   localparam int SUSPEND_B  = 7;
   localparam int BUSRST_B   = 8;
   localparam int LINE_LSB   = 10;

   // Change flag sources, in order of their flag bits 1, 3, 5
   localparam int NUM_CHG = 3;
   localparam int IX_CONN = 0;
   localparam int IX_EN   = 1;
   localparam int IX_OVC  = 2;

   localparam logic [7:0] W1C_MASK = 8'h2E;

   typedef struct packed {
      logic pwr;
      logic busrst;
      logic susp;
      logic res;
   } port_ctl_t;

   function automatic int chg_bit(input int idx);
      return 2 * idx + 1;
   endfunction

endpackage

// File: rtl/hport_chg_flag.sv
module hport_chg_flag (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
         flag_o <= 1'b0;
      else if (set_i)
         flag_o <= 1'b1;
      else if (clr_i)
         flag_o <= 1'b0;
   end

   // R5
   set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i |=> flag_o);

   // R4
   w1c_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_o && !clr_i) |=> flag_o);

   // R2
   no_spurious_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!flag_o && !set_i) |=> !flag_o);

endmodule

// File: rtl/hport_en_ctl.sv
module hport_en_ctl (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic conn_now_i,
   input  logic conn_seen_i,
   input  logic ovc_now_i,
   input  logic grant_i,
   input  logic sw_clr_i,
   output logic en_o,
   output logic drop_o
);

   logic lost;

   assign lost   = !conn_now_i || ovc_now_i;
   assign drop_o = en_o && lost;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
         en_o <= 1'b0;
      else if (lost)
         en_o <= 1'b0;
      else if (sw_clr_i)
         en_o <= 1'b0;
      else if (grant_i && conn_seen_i)
         en_o <= 1'b1;
   end

   // R6
   no_sw_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!en_o && !grant_i) |=> !en_o);

   // R6
   sw_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_o && sw_clr_i) |=> !en_o);

   // R7
   auto_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!conn_now_i || ovc_now_i) |=> !en_o);

endmodule

// File: rtl/hport_ctl_fields.sv
module hport_ctl_fields
   import hport_pkg::*;
#(
   parameter int TEST_W   = 4,
   parameter bit HAS_TEST = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_en_i,
   input  port_ctl_t         ctl_d_i,
   input  logic [TEST_W-1:0] test_d_i,
   output port_ctl_t         ctl_o,
   output logic [TEST_W-1:0] test_o
);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
         ctl_o <= '0;
      else if (wr_en_i)
         ctl_o <= ctl_d_i;
   end

   if (HAS_TEST) begin : g_test
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)
            test_o <= '0;
         else if (wr_en_i)
            test_o <= test_d_i;
      end
   end else begin : g_no_test
      logic unused_test;
      assign unused_test = ^test_d_i;
      assign test_o      = '0;
   end

   // R8
   ctl_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wr_en_i |=> ($stable(ctl_o) && $stable(test_o)));

endmodule

// File: rtl/hport_port_reg.sv
module hport_port_reg
   import hport_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int LINE_W   = 2,
   parameter int TEST_W   = 4,
   parameter int SPD_W    = 2,
   parameter bit HAS_TEST = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_en_i,
   input  logic [DATA_W-1:0] wr_data_i,
   output logic [DATA_W-1:0] rd_data_o,
   input  logic              conn_i,
   input  logic              ovc_i,
   input  logic              en_grant_i,
   input  logic [LINE_W-1:0] line_i,
   input  logic [SPD_W-1:0]  speed_i,
   output logic              port_pwr_o,
   output logic              port_rst_o,
   output logic              port_susp_o,
   output logic              port_res_o,
   output logic [TEST_W-1:0] port_test_o,
   output logic              port_en_o,
   output logic              port_irq_o
);

   localparam int PWR_B    = LINE_LSB + LINE_W;
   localparam int TEST_LSB = PWR_B + 1;
   localparam int SPD_LSB  = TEST_LSB + TEST_W;
   localparam int USED_W   = SPD_LSB + SPD_W;

   if (LINE_W < 1 || LINE_W > 4) begin : g_bad_line
      $error("hport_port_reg: LINE_W out of range");
   end
   if (TEST_W < 1 || TEST_W > 8) begin : g_bad_test
      $error("hport_port_reg: TEST_W out of range");
   end
   if (SPD_W < 1 || SPD_W > 4) begin : g_bad_spd
      $error("hport_port_reg: SPD_W out of range");
   end
   if (DATA_W < USED_W) begin : g_bad_data
      $error("hport_port_reg: DATA_W too narrow for the field layout");
   end

   // Sampled sideband state
   logic              conn_q, ovc_q;
   logic [LINE_W-1:0] line_q;
   logic [SPD_W-1:0]  spd_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         conn_q <= 1'b0;
         ovc_q  <= 1'b0;
         line_q <= '0;
         spd_q  <= '0;
      end else begin
         conn_q <= conn_i;
         ovc_q  <= ovc_i;
         line_q <= line_i;
         spd_q  <= speed_i;
      end
   end

   // Port enable
   logic en_q, en_drop;

   hport_en_ctl u_en (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .conn_now_i  (conn_i),
      .conn_seen_i (conn_q),
      .ovc_now_i   (ovc_i),
      .grant_i     (en_grant_i),
      .sw_clr_i    (wr_en_i && wr_data_i[EN_B]),
      .en_o        (en_q),
      .drop_o      (en_drop)
   );

   // Change flags
   logic [NUM_CHG-1:0] chg_set, chg_q;

   assign chg_set[IX_CONN] = conn_i ^ conn_q;
   assign chg_set[IX_EN]   = en_drop;
   assign chg_set[IX_OVC]  = ovc_i ^ ovc_q;

   for (genvar g = 0; g < NUM_CHG; g++) begin : g_chg
      hport_chg_flag u_flag (
         .clk_i  (clk_i),
         .rst_ni (rst_ni),
         .set_i  (chg_set[g]),
         .clr_i  (wr_en_i && wr_data_i[chg_bit(g)]),
         .flag_o (chg_q[g])
      );
   end

   // Control fields
   port_ctl_t ctl_d, ctl_q;

   always_comb begin
      ctl_d.pwr    = wr_data_i[PWR_B];
      ctl_d.busrst = wr_data_i[BUSRST_B];
      ctl_d.susp   = wr_data_i[SUSPEND_B];
      ctl_d.res    = wr_data_i[RESUME_B];
   end

   hport_ctl_fields #(
      .TEST_W   (TEST_W),
      .HAS_TEST (HAS_TEST)
   ) u_ctl (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_en_i  (wr_en_i),
      .ctl_d_i  (ctl_d),
      .test_d_i (wr_data_i[TEST_LSB +: TEST_W]),
      .ctl_o    (ctl_q),
      .test_o   (port_test_o)
   );

   logic unused_wr;
   assign unused_wr = ^{wr_data_i[CONN_STS_B], wr_data_i[OVC_STS_B], wr_data_i[9],
                        wr_data_i[LINE_LSB +: LINE_W], wr_data_i[DATA_W-1:SPD_LSB]};

   // Registered interrupt
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
         port_irq_o <= 1'b0;
      else
         port_irq_o <= |chg_q;
   end

   // Read assembly
   always_comb begin
      rd_data_o                       = '0;
      rd_data_o[CONN_STS_B]           = conn_q;
      rd_data_o[EN_B]                 = en_q;
      rd_data_o[OVC_STS_B]            = ovc_q;
      rd_data_o[RESUME_B]             = ctl_q.res;
      rd_data_o[SUSPEND_B]            = ctl_q.susp;
      rd_data_o[BUSRST_B]             = ctl_q.busrst;
      rd_data_o[LINE_LSB +: LINE_W]   = line_q;
      rd_data_o[PWR_B]                = ctl_q.pwr;
      rd_data_o[TEST_LSB +: TEST_W]   = port_test_o;
      rd_data_o[SPD_LSB +: SPD_W]     = spd_q;
      for (int i = 0; i < NUM_CHG; i++)
         rd_data_o[chg_bit(i)] = chg_q[i];
   end

   assign port_pwr_o  = ctl_q.pwr;
   assign port_rst_o  = ctl_q.busrst;
   assign port_susp_o = ctl_q.susp;
   assign port_res_o  = ctl_q.res;
   assign port_en_o   = en_q;

   // R10
   irq_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(port_irq_o) |-> $past(chg_q != '0));

   // R10
   irq_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(port_irq_o) |-> $past(chg_q == '0));

   // R7
   drop_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (port_en_o && ovc_i) |=> chg_q[IX_EN]);

endmodule

// File: tb/hport_port_reg_tb.sv
`timescale 1ns/1ps
module hport_port_reg_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic        conn = 1'b0, ovc = 1'b0, grant = 1'b0;
   logic [1:0]  line = '0, speed = '0;
   logic        pwr, brst, susp, res, en, irq;
   logic [3:0]  test;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   hport_port_reg #(
      .DATA_W(32), .LINE_W(2), .TEST_W(4), .SPD_W(2), .HAS_TEST(1'b1)
   ) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
      .rd_data_o(rd_data), .conn_i(conn), .ovc_i(ovc), .en_grant_i(grant),
      .line_i(line), .speed_i(speed), .port_pwr_o(pwr), .port_rst_o(brst),
      .port_susp_o(susp), .port_res_o(res), .port_test_o(test),
      .port_en_o(en), .port_irq_o(irq)
   );

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic reg_write(input logic [31:0] d);
      wr_en   = 1'b1;
      wr_data = d;
      tick();
      wr_en   = 1'b0;
      wr_data = '0;
   endtask

   task automatic pulse_grant();
      grant = 1'b1;
      tick();
      grant = 1'b0;
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      check("R1 read value", rd_data, 32'h0);
      check("R1 irq", {31'b0, irq}, 32'h0);
      check("R1 outputs", {25'b0, en, pwr, brst, susp, res, test}, 32'h0);
   endtask

   task automatic t_ctl_fields();
      // power 12, reset 8, suspend 7, resume 6, test 0xA at 16:13
      reg_write(32'h1000 | 32'h100 | 32'h80 | 32'h40 | (32'hA << 13));
      check("R8 readback all", rd_data, 32'h1000 | 32'h100 | 32'h80 | 32'h40 | (32'hA << 13));
      check("R8 outputs all", {27'b0, pwr, brst, susp, res, 1'b0}, 32'h1E);
      check("R8 test out", {28'b0, test}, 32'hA);
      reg_write(32'h1000);
      check("R8 readback power only", rd_data, 32'h1000);
      check("R8 outputs power only", {28'b0, pwr, brst, susp, res}, 32'h8);
      reg_write(32'h0);
   endtask

   task automatic t_ro_fields();
      line  = 2'b10;
      speed = 2'b01;
      tick();
      check("R9 line state", {30'b0, rd_data[11:10]}, 32'h2);
      check("R9 speed", {30'b0, rd_data[18:17]}, 32'h1);
      reg_write(32'h00060C00 | 32'h11);
      check("R9 write ignored", rd_data, (32'h2 << 10) | (32'h1 << 17));
      line  = '0;
      speed = '0;
      tick();
      check("R9 follows input", rd_data, 32'h0);
   endtask

   task automatic t_connect();
      conn = 1'b1;
      tick();
      check("R2 status and flag", rd_data, 32'h3);
      check("R10 irq not yet", {31'b0, irq}, 32'h0);
      tick();
      check("R10 irq rises", {31'b0, irq}, 32'h1);
      reg_write(32'h0);
      check("R4 zero write keeps flag", rd_data, 32'h3);
      reg_write(32'h2);
      check("R4 one clears flag", rd_data, 32'h1);
      check("R10 irq still high", {31'b0, irq}, 32'h1);
      tick();
      check("R10 irq falls", {31'b0, irq}, 32'h0);
   endtask

   task automatic t_enable();
      pulse_grant();
      check("R6 grant sets enable", rd_data, 32'h5);
      check("R6 enable output", {31'b0, en}, 32'h1);
      reg_write(32'h0);
      check("R6 zero write keeps enable", rd_data, 32'h5);
      reg_write(32'h4);
      check("R7 sw clear no change flag", rd_data, 32'h1);
      reg_write(32'h4);
      check("R6 write cannot set", rd_data, 32'h1);
   endtask

   task automatic t_rmw();
      logic [31:0] v;
      conn = 1'b0;
      tick();
      reg_write(32'h2);
      conn = 1'b1;
      tick();
      pulse_grant();
      v = rd_data;
      check("R11 start value", v, 32'h7);
      reg_write((v & ~32'h2E) | 32'h1000);
      check("R11 masked write keeps flags", rd_data, 32'h1007);
      reg_write(v);
      check("R11 raw write clears", rd_data, 32'h1);
   endtask

   task automatic t_disconnect();
      pulse_grant();
      check("R6 enable again", rd_data, 32'h5);
      conn = 1'b0;
      tick();
      check("R7 disconnect drops enable", rd_data, 32'hA);
      pulse_grant();
      check("R6 grant ignored unconnected", rd_data, 32'hA);
      reg_write(32'h2E);
      check("R4 clear all flags", rd_data, 32'h0);
      tick();
      check("R10 irq low", {31'b0, irq}, 32'h0);
   endtask

   task automatic t_overcurrent();
      conn = 1'b1;
      tick();
      reg_write(32'h2);
      pulse_grant();
      check("R6 enabled before fault", rd_data, 32'h5);
      ovc = 1'b1;
      tick();
      check("R3 R7 overcurrent", rd_data, 32'h39);
      reg_write(32'h20);
      check("R4 single flag clear", rd_data, 32'h19);
      ovc = 1'b0;
      tick();
      check("R3 falling edge flag", rd_data, 32'h29);
   endtask

   task automatic t_set_wins();
      ovc = 1'b1;
      reg_write(32'h20);
      check("R5 set beats clear", rd_data, 32'h39);
      reg_write(32'h2E);
      check("R5 later clear works", rd_data, 32'h11);
      tick();
      check("R10 irq cleared", {31'b0, irq}, 32'h0);
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin
      t_reset();
      t_ctl_fields();
      t_ro_fields();
      t_connect();
      t_enable();
      t_rmw();
      t_disconnect();
      t_overcurrent();
      t_set_wins();
      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      #50000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

endmodule